// File: doc/BRIEF.md
# Single-Bank Prioritised Interrupt Controller

This block collects up to 32 interrupt request lines and delivers at most one request on each of two processor lines: a normal request line and a fast request line. Software programs it through a small register window. Each source gets its own configuration word with three fields: a 5-bit priority, a choice between edge and level sensing, and a choice of processor line. Sources can be masked one by one, and a global gate holds back both outputs until software opens it.

When at least one pending, unmasked source is steered to a line, the block picks the winner for that line and raises the line. The winner is chosen by lowest priority value, and among equal priorities by lowest source index. The winner's index is captured in a readable register and held there until software acknowledges the line through a control register. Acknowledging an edge-sensed winner also clears its pending bit. If more requests remain, the line rises again one clock later with the next winner. Only the first bank of a larger system may use the fast line, and a parameter selects this. In a cascaded system the lower-level controller's output is wired to one of the sources here as a level-sensed input. Software then acknowledges the lower level first and this block second.

Top module: `bank_intc`

## Requirements
- R1: The mask register (byte offset 0x000) resets to all ones, one bit per source. A 1 blocks that source from arbitration while its pending bit still latches. A 0 lets the source take part.
- R2: Source i has a configuration word at byte offset 0x100 + 4*i. Bit 0 steers the source to the fast line when set. Bit 1 selects level sensing when set and edge sensing when clear. Bits 6:2 hold the priority. The word reads back those 7 bits with all higher bits zero.
- R3: When parameter FIQ_EN is 0, bit 0 of every configuration word is stored and read as 0, every source goes to the normal line, and the fast output never rises.
- R4: The pending register (offset 0x004) shows one bit per source. A level source's bit follows its input, delayed by one clock. An edge source's bit is set by a 0-to-1 transition and stays set until it is cleared.
- R5: Writing the pending register clears each latched edge-pending bit whose write-data bit is 0, so writing 0 clears all of them. Level-sensed bits are not affected.
- R6: Among candidates for one line, the lowest priority value wins and a tie goes to the lowest source index. The captured winner index reads at offset 0x008 for the normal line and at 0x00C for the fast line.
- R7: Each output is registered. It rises on the clock after an eligible candidate exists while the global gate is open. It then stays high, with its winner index unchanged, until it is acknowledged, even if a higher-priority source arrives.
- R8: Writing the control register (offset 0x010) with bit 0 set acknowledges the normal line, and bit 1 set acknowledges the fast line. An acknowledged line drops on that clock and the winner's edge-pending bit is cleared. The line rises again one clock later if another candidate is waiting.
- R9: The global gate register (offset 0x014) resets to 1. While it holds 1, both outputs are low. Writing 0 allows delivery.
- R10: After reset both outputs are low, the pending register reads 0 and both winner indices read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt request lines, synchronous to clk |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | DATA_W | Register write data |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe; rdata_o is valid after the next edge |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
The bench builds two copies of the block. The first uses the default 32 sources with the fast line enabled, which exercises both lines, the full mask width, the tie-break between sources of equal priority, and the interaction between frozen winners and acknowledges. The second has 8 sources and FIQ_EN set to 0. It shows that the reset mask covers exactly the configured width, and that a source programmed for the fast line reads back with the steering bit cleared and is delivered on the normal line.

// File: rtl/bank_intc_pkg.sv
package bank_intc_pkg;

  localparam int PRIO_W = 5;

  localparam logic [9:0] OFS_MASK  = 10'h000;
  localparam logic [9:0] OFS_PEND  = 10'h004;
  localparam logic [9:0] OFS_NWIN  = 10'h008;
  localparam logic [9:0] OFS_FWIN  = 10'h00C;
  localparam logic [9:0] OFS_CTRL  = 10'h010;
  localparam logic [9:0] OFS_GATE  = 10'h014;
  localparam logic [9:0] OFS_CFG   = 10'h100;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              lvl;
    logic              fast;
  } src_cfg_t;

endpackage

// File: rtl/bank_intc_rstsync.sv
module bank_intc_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/bank_intc_latch.sv
module bank_intc_latch #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] lvl_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);

  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] pend_n;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      if (lvl_i[i]) pend_n[i] = src_i[i];
      else          pend_n[i] = (src_i[i] & ~prev_q[i]) | (pend_q[i] & ~clr_i[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= src_i;
      pend_q <= pend_n;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/bank_intc_arb.sv
module bank_intc_arb #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 5,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             cand_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                           any_o,
  output logic [IDX_W-1:0]               idx_o
);

  logic              found;
  logic [PRIO_W-1:0] best_p;
  logic [IDX_W-1:0]  best_i;

  always_comb begin
    found  = 1'b0;
    best_p = '1;
    best_i = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand_i[i] && (!found || (prio_i[i] < best_p))) begin
        found  = 1'b1;
        best_p = prio_i[i];
        best_i = IDX_W'(i);
      end
    end
  end

  assign any_o = found;
  assign idx_o = best_i;

endmodule

// File: rtl/bank_intc_chan.sv
module bank_intc_chan #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 5,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC-1:0]             cand_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic                           gate_i,
  input  logic                           ack_i,
  output logic                           out_o,
  output logic                           any_o,
  output logic [IDX_W-1:0]               win_o,
  output logic [NUM_SRC-1:0]             clr_o
);

  logic             out_q, out_n;
  logic [IDX_W-1:0] win_q, win_n;
  logic             any;
  logic [IDX_W-1:0] best;

  bank_intc_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .cand_i (cand_i),
    .prio_i (prio_i),
    .any_o  (any),
    .idx_o  (best)
  );

  always_comb begin
    out_n = out_q;
    win_n = win_q;
    if (out_q) begin
      if (ack_i || gate_i) out_n = 1'b0;
    end else if (!gate_i && any) begin
      out_n = 1'b1;
      win_n = best;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      win_q <= '0;
    end else begin
      out_q <= out_n;
      win_q <= win_n;
    end
  end

  assign clr_o = (ack_i && out_q) ? (NUM_SRC'(1) << win_q) : '0;
  assign out_o = out_q;
  assign any_o = any;
  assign win_o = win_q;

endmodule

// File: rtl/bank_intc.sv
module bank_intc
  import bank_intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int FIQ_EN  = 1,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);

  localparam logic              FAST_OK  = (FIQ_EN != 0);
  localparam logic [ADDR_W-1:0] CFG_SPAN = ADDR_W'(4 * NUM_SRC);

  logic rst_n_s;

  bank_intc_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_s));

  // register state
  logic [NUM_SRC-1:0]            mask_q, mask_n;
  logic                          gmask_q, gmask_n;
  src_cfg_t [NUM_SRC-1:0]        cfg_q, cfg_n;
  logic [DATA_W-1:0]             rdata_q, rdata_n;

  // decode
  logic              wr_mask, wr_pend, wr_ctrl, wr_gate, wr_cfg;
  logic [ADDR_W-1:0] cfg_off;
  logic              in_cfg;
  logic [IDX_W-1:0]  cfg_idx;
  logic [1:0]        ack_v;

  assign cfg_off = addr_i - ADDR_W'(OFS_CFG);
  assign in_cfg  = (addr_i >= ADDR_W'(OFS_CFG)) && (cfg_off < CFG_SPAN) && (cfg_off[1:0] == 2'b00);
  assign cfg_idx = cfg_off[IDX_W+1:2];

  assign wr_mask = wr_en_i && (addr_i == ADDR_W'(OFS_MASK));
  assign wr_pend = wr_en_i && (addr_i == ADDR_W'(OFS_PEND));
  assign wr_ctrl = wr_en_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign wr_gate = wr_en_i && (addr_i == ADDR_W'(OFS_GATE));
  assign wr_cfg  = wr_en_i && in_cfg;
  assign ack_v   = {wr_ctrl & wdata_i[1], wr_ctrl & wdata_i[0]};

  // per-source field vectors
  logic [NUM_SRC-1:0]             lvl_v, fast_v, pend_v, clr_v;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_v;
  logic [1:0][NUM_SRC-1:0]        cand_v;
  logic [1:0][NUM_SRC-1:0]        chan_clr;
  logic [1:0][IDX_W-1:0]          chan_win;
  logic [1:0]                     chan_out;
  logic [1:0]                     chan_any;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      lvl_v[i]  = cfg_q[i].lvl;
      fast_v[i] = cfg_q[i].fast;
      prio_v[i] = cfg_q[i].prio;
    end
  end

  assign cand_v[0] = pend_v & ~mask_q & ~fast_v;
  assign cand_v[1] = pend_v & ~mask_q & fast_v;
  assign clr_v     = (wr_pend ? ~wdata_i[NUM_SRC-1:0] : '0) | chan_clr[0] | chan_clr[1];

  bank_intc_latch #(.NUM_SRC(NUM_SRC)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .src_i  (src_i),
    .lvl_i  (lvl_v),
    .clr_i  (clr_v),
    .pend_o (pend_v)
  );

  for (genvar c = 0; c < 2; c++) begin : g_chan
    bank_intc_chan #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .cand_i (cand_v[c]),
      .prio_i (prio_v),
      .gate_i (gmask_q),
      .ack_i  (ack_v[c]),
      .out_o  (chan_out[c]),
      .any_o  (chan_any[c]),
      .win_o  (chan_win[c]),
      .clr_o  (chan_clr[c])
    );
  end

  // next-state for software registers
  always_comb begin
    mask_n  = mask_q;
    gmask_n = gmask_q;
    cfg_n   = cfg_q;
    if (wr_mask) mask_n  = wdata_i[NUM_SRC-1:0];
    if (wr_gate) gmask_n = wdata_i[0];
    if (wr_cfg) begin
      cfg_n[cfg_idx].prio = wdata_i[PRIO_W+1:2];
      cfg_n[cfg_idx].lvl  = wdata_i[1];
      cfg_n[cfg_idx].fast = wdata_i[0] & FAST_OK;
    end
  end

  // read mux
  always_comb begin
    rdata_n = '0;
    if (in_cfg) begin
      rdata_n = DATA_W'({cfg_q[cfg_idx].prio, cfg_q[cfg_idx].lvl, cfg_q[cfg_idx].fast});
    end else begin
      case (addr_i)
        ADDR_W'(OFS_MASK): rdata_n = DATA_W'(mask_q);
        ADDR_W'(OFS_PEND): rdata_n = DATA_W'(pend_v);
        ADDR_W'(OFS_NWIN): rdata_n = DATA_W'(chan_win[0]);
        ADDR_W'(OFS_FWIN): rdata_n = DATA_W'(chan_win[1]);
        ADDR_W'(OFS_GATE): rdata_n = DATA_W'(gmask_q);
        default:           rdata_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mask_q  <= '1;
      gmask_q <= 1'b1;
      cfg_q   <= '0;
      rdata_q <= '0;
    end else begin
      mask_q  <= mask_n;
      gmask_q <= gmask_n;
      cfg_q   <= cfg_n;
      if (rd_en_i) rdata_q <= rdata_n;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = chan_out[0];
  assign fiq_o   = chan_out[1];

endmodule

// File: rtl/bank_intc_chk.sv
module bank_intc_chk #(
  parameter int IDX_W  = 5,
  parameter int FIQ_EN = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_o,
  input logic             fiq_o,
  input logic             gmask_q,
  input logic             irq_any,
  input logic             fiq_any,
  input logic [IDX_W-1:0] irq_win,
  input logic [IDX_W-1:0] fiq_win,
  input logic             ack_irq,
  input logic             ack_fiq
);

  // R9: a closed gate silences both lines on the next clock
  a_r9_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    gmask_q |=> (!irq_o && !fiq_o));

  // R7: winner index stays put while a line is held
  a_r7_irq_win_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> $stable(irq_win));

  a_r7_fiq_win_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |=> $stable(fiq_win));

  // R7: a line only rises when a candidate existed
  a_r7_irq_needs_cand: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(irq_any));

  a_r7_fiq_needs_cand: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> $past(fiq_any));

  // R8: an acknowledge drops the held line
  a_r8_irq_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ack_irq) |=> !irq_o);

  a_r8_fiq_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_o && ack_fiq) |=> !fiq_o);

  // R3: banks without fast routing never raise the fast line
  a_r3_no_fast_line: assert property (@(posedge clk) disable iff (!rst_n)
    (FIQ_EN == 0) |-> !fiq_o);

endmodule

bind bank_intc bank_intc_chk #(.IDX_W(IDX_W), .FIQ_EN(FIQ_EN)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq_o   (irq_o),
  .fiq_o   (fiq_o),
  .gmask_q (gmask_q),
  .irq_any (chan_any[0]),
  .fiq_any (chan_any[1]),
  .irq_win (chan_win[0]),
  .fiq_win (chan_win[1]),
  .ack_irq (ack_v[0]),
  .ack_fiq (ack_v[1])
);

// File: tb/bank_intc_test.sv
module bank_intc_test;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic [9:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
  } vec_t;

  // table: configuration writes and readbacks on the 32-source instance
  localparam vec_t TBL [12] = '{
    '{1'b1, 10'h10C, 32'h16,       32'h0},        // R2 src3 level prio5 normal
    '{1'b0, 10'h10C, 32'h0,        32'h16},       // R2 readback
    '{1'b1, 10'h124, 32'h14,       32'h0},        // R2 src9 edge prio5 normal
    '{1'b1, 10'h130, 32'h0A,       32'h0},        // R2 src12 level prio2 normal
    '{1'b1, 10'h150, 32'h05,       32'h0},        // R3 src20 edge prio1 fast
    '{1'b0, 10'h150, 32'h0,        32'h05},       // R3 fast bit kept in bank 0
    '{1'b1, 10'h110, 32'hFFFFFFFF, 32'h0},        // R2 all ones
    '{1'b0, 10'h110, 32'h0,        32'h7F},       // R2 only 7 bits stored
    '{1'b1, 10'h000, 32'hFFEFEDF7, 32'h0},        // R1 unmask 3,9,12,20
    '{1'b0, 10'h000, 32'h0,        32'hFFEFEDF7}, // R1 readback
    '{1'b1, 10'h014, 32'h0,        32'h0},        // R9 open gate
    '{1'b0, 10'h014, 32'h0,        32'h0}         // R9 readback
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] src1;
  logic [7:0]  src2;
  logic [9:0]  addr;
  logic [31:0] wdata;
  logic        wr1, rd1, wr2, rd2;
  logic [31:0] rdata1, rdata2;
  logic        irq1, fiq1, irq2, fiq2;

  int checks;
  int errors;

  bank_intc uut (
    .clk(clk), .rst_n(rst_n), .src_i(src1), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr1), .rd_en_i(rd1), .rdata_o(rdata1), .irq_o(irq1), .fiq_o(fiq1)
  );

  bank_intc #(.NUM_SRC(8), .FIQ_EN(0)) uut2 (
    .clk(clk), .rst_n(rst_n), .src_i(src2), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr2), .rd_en_i(rd2), .rdata_o(rdata2), .irq_o(irq2), .fiq_o(fiq2)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit u2, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (u2) wr2 = 1'b1; else wr1 = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr1 = 1'b0; wr2 = 1'b0;
  endtask

  task automatic rd(input bit u2, input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    if (u2) rd2 = 1'b1; else rd1 = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd1 = 1'b0; rd2 = 1'b0;
    d = u2 ? rdata2 : rdata1;
  endtask

  task automatic pulse1(input int idx);
    @(negedge clk); src1[idx] = 1'b1;
    @(negedge clk); src1[idx] = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    checks = 0; errors = 0;
    rst_n = 1'b0; src1 = '0; src2 = '0; addr = '0; wdata = '0;
    wr1 = 0; rd1 = 0; wr2 = 0; rd2 = 0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // reset state
    chk("R10 irq after reset", 32'(irq1), 32'h0);
    chk("R10 fiq after reset", 32'(fiq1), 32'h0);
    rd(0, 10'h000, v); chk("R1 mask reset", v, 32'hFFFFFFFF);
    rd(0, 10'h014, v); chk("R9 gate reset", v, 32'h1);
    rd(0, 10'h004, v); chk("R10 pending reset", v, 32'h0);
    rd(0, 10'h008, v); chk("R10 winner reset", v, 32'h0);

    // table walk
    for (int k = 0; k < 12; k++) begin
      if (TBL[k].wr) wr(0, TBL[k].a, TBL[k].d);
      else begin
        rd(0, TBL[k].a, v);
        chk($sformatf("R2 table entry %0d", k), v, TBL[k].exp);
      end
    end

    // edge source latches and wins
    pulse1(9); tick(3);
    chk("R7 irq raised", 32'(irq1), 32'h1);
    rd(0, 10'h004, v); chk("R4 edge latched", v, 32'h200);
    rd(0, 10'h008, v); chk("R6 winner 9", v, 32'd9);

    // higher priority arrives, winner stays frozen
    src1[12] = 1'b1; tick(3);
    rd(0, 10'h008, v); chk("R7 winner frozen", v, 32'd9);
    chk("R7 irq held", 32'(irq1), 32'h1);

    // acknowledge drops then reasserts with next
    wr(0, 10'h010, 32'h1);
    chk("R8 irq drops on ack", 32'(irq1), 32'h0);
    tick(1);
    chk("R8 irq reasserts", 32'(irq1), 32'h1);
    rd(0, 10'h004, v); chk("R8 edge pend cleared", v, 32'h1000);
    rd(0, 10'h008, v); chk("R6 winner 12", v, 32'd12);

    src1[12] = 1'b0; tick(2);
    wr(0, 10'h010, 32'h1); tick(3);
    chk("R7 idle with no candidate", 32'(irq1), 32'h0);

    // tie at equal priority goes to lower index
    @(negedge clk); src1[3] = 1'b1; src1[9] = 1'b1;
    @(negedge clk); src1[9] = 1'b0;
    tick(3);
    rd(0, 10'h008, v); chk("R6 tie lowest index", v, 32'd3);
    src1[3] = 1'b0; tick(2);
    wr(0, 10'h010, 32'h1); tick(2);
    chk("R8 reassert for edge source", 32'(irq1), 32'h1);
    rd(0, 10'h008, v); chk("R6 winner after tie", v, 32'd9);
    wr(0, 10'h010, 32'h1); tick(3);
    chk("R8 irq idle after last", 32'(irq1), 32'h0);
    rd(0, 10'h004, v); chk("R8 pending empty", v, 32'h0);

    // fast line
    pulse1(20); tick(3);
    chk("R3 fast line raised", 32'(fiq1), 32'h1);
    chk("R3 normal line quiet", 32'(irq1), 32'h0);
    rd(0, 10'h00C, v); chk("R6 fast winner 20", v, 32'd20);
    wr(0, 10'h010, 32'h2);
    chk("R8 fast drops on ack", 32'(fiq1), 32'h0);
    tick(3);
    chk("R8 fast stays low", 32'(fiq1), 32'h0);

    // gate closed, pending clear
    wr(0, 10'h014, 32'h1);
    @(negedge clk); src1[3] = 1'b1; src1[5] = 1'b1; src1[9] = 1'b1;
    @(negedge clk); src1[5] = 1'b0; src1[9] = 1'b0;
    tick(3);
    chk("R9 gate blocks irq", 32'(irq1), 32'h0);
    rd(0, 10'h004, v); chk("R4 pending set", v, 32'h228);
    wr(0, 10'h004, 32'hFFFFFFDF);
    rd(0, 10'h004, v); chk("R5 selective clear", v, 32'h208);
    wr(0, 10'h004, 32'h0);
    rd(0, 10'h004, v); chk("R5 clear all edge bits", v, 32'h8);
    wr(0, 10'h014, 32'h0); tick(2);
    chk("R9 gate opens delivery", 32'(irq1), 32'h1);
    rd(0, 10'h008, v); chk("R6 winner 3", v, 32'd3);
    src1[3] = 1'b0; tick(2);
    wr(0, 10'h010, 32'h1); tick(3);

    // masked source latches but never wins
    pulse1(5); tick(3);
    chk("R1 masked source quiet", 32'(irq1), 32'h0);
    rd(0, 10'h004, v); chk("R4 masked still latches", v, 32'h20);
    wr(0, 10'h004, 32'h0);

    // second instance: no fast routing, 8 sources
    rd(1, 10'h000, v); chk("R1 narrow mask reset", v, 32'hFF);
    wr(1, 10'h108, 32'h01);
    rd(1, 10'h108, v); chk("R3 fast bit forced 0", v, 32'h0);
    wr(1, 10'h000, 32'h0);
    wr(1, 10'h014, 32'h0);
    @(negedge clk); src2[2] = 1'b1;
    @(negedge clk); src2[2] = 1'b0;
    tick(3);
    chk("R3 routed to normal line", 32'(irq2), 32'h1);
    chk("R3 fast line stays low", 32'(fiq2), 32'h0);
    rd(1, 10'h008, v); chk("R6 narrow winner 2", v, 32'd2);

    finish_run();
  end

endmodule